// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block carries out the state changes a 64-bit processor with windowed registers makes when it takes a trap. When the take strobe is high, it records the interrupted context in a trap-stack entry. It then raises the trap level and picks the privileged mode and global register set. For window traps it moves the window pointer, and it computes the vector address the processor fetches from next.

The surrounding pipeline supplies the trap type and the live architectural state: PC, NPC, condition codes, address-space identifier, processor state word, window pointer, the count of savable windows and the trap base address. The block keeps the trap level and the trap stack itself. A trap-return unit can read any stack level through a registered read port. All updates happen at the clock edge that samples the strobe. A done pulse in the next cycle marks the new outputs as valid. A trap arriving when the level is already saturated puts the block into a sticky error state instead.

Top module: `trap_entry_seq`

## Requirements
- R1: A trap taken while the trap level is at or above MAXTL sets the error output `err_o`, which stays high until reset. That trap leaves the level, the stack and every registered output unchanged, and `done_o` stays low.
- R2: Reset clears the trap level to 0. Each accepted trap raises it by exactly one.
- R3: The red-state bit (bit 5 of the state word) is set in `pstate_o` when a trap arrives with the level at MAXTL-1. Otherwise it is copied from `pstate_i`.
- R4: The saved state word is 40 bits. Condition codes go in bits 39:32 and the ASI in bits 31:24. Bits 19:8 hold `pstate_i` ANDed with 0xF3F, the window pointer sits in the lowest bits, and all other bits are 0.
- R5: The accepted trap writes the saved state, PC, NPC and trap type to the stack entry for the new level. Presenting level L on `rd_lvl_i` returns that entry one cycle later.
- R6: `pstate_o` has the FPU-enable bit (bit 4) and the privileged bit (bit 2) set. Exactly one global-set bit is set:
  - bit 11 for trap type 0x060;
  - bit 10 for types 0x008, 0x030 and 0x064 to 0x06F;
  - bit 0 for all other types.

  All remaining bits are copied from `pstate_i`.
- R7: The new window pointer is computed modulo NWIN:
  - CWP-1 for trap type 0x024;
  - CWP-CANSAVE-2 when type bits 8:6 are 010;
  - CWP+1 when type bits 8:6 are 011;
  - unchanged for all other types.
- R8: The new PC takes bits above 14 from the trap base. Bit 14 is 1 when the new level exceeds 1, bits 13:5 hold the trap type, and bits 4:0 are 0.
- R9: The new NPC equals the new PC plus 4.
- R10: `done_o` is high in the cycle after an accepted take strobe, and only then. The registered outputs hold their values between traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Take-trap strobe |
| tt_i | input | 9 | Trap type |
| pc_i | input | AW | PC at the trap |
| npc_i | input | AW | NPC at the trap |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Address-space identifier |
| pstate_i | input | 12 | Processor state word |
| cwp_i | input | log2(NWIN) | Current window pointer |
| cansave_i | input | log2(NWIN) | Windows available to save |
| tba_i | input | AW | Trap base address |
| rd_lvl_i | input | log2(MAXTL+1) | Stack level to read (1..MAXTL) |
| done_o | output | 1 | Trap accepted last cycle |
| err_o | output | 1 | Sticky error state |
| tl_o | output | log2(MAXTL+1) | Current trap level |
| pstate_o | output | 12 | Updated state word |
| cwp_o | output | log2(NWIN) | Updated window pointer |
| pc_o | output | AW | Vector address |
| npc_o | output | AW | Next PC after the vector |
| rd_tstate_o | output | 40 | Saved state word at read level |
| rd_tpc_o | output | AW | Saved PC at read level |
| rd_tnpc_o | output | AW | Saved NPC at read level |
| rd_tt_o | output | 9 | Saved trap type at read level |

## Verification
The assertions assume that the take strobe is a clean, single-bit level sampled at the clock edge. They also assume that `rd_lvl_i` only selects levels that were written since reset, because unwritten stack entries hold no defined value. The bench resets before each trap-type or window sweep point, so every level it reads has just been written. It holds `cansave_i` and `cwp_i` inside the window range. It also lets the level reach MAXTL only in the dedicated saturation scenario, where the error path is checked.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int TTW    = 9;
  localparam int PSW    = 12;
  localparam int CCRW   = 8;
  localparam int ASIW   = 8;
  localparam int SAVEW  = 40;

  localparam logic [TTW-1:0] TT_CLEAN_WIN  = 9'h024;
  localparam logic [TTW-1:0] TT_INT_VEC    = 9'h060;
  localparam logic [TTW-1:0] TT_INSN_FAULT = 9'h008;
  localparam logic [TTW-1:0] TT_DATA_FAULT = 9'h030;
  localparam logic [TTW-1:0] TT_INSN_MISS  = 9'h064;
  localparam logic [TTW-1:0] TT_DATA_MISS  = 9'h068;
  localparam logic [TTW-1:0] TT_DATA_PROT  = 9'h06C;
  localparam logic [2:0]     TT_GRP_SPILL  = 3'b010;
  localparam logic [2:0]     TT_GRP_FILL   = 3'b011;

  localparam int PS_AG   = 0;
  localparam int PS_PRIV = 2;
  localparam int PS_PEF  = 4;
  localparam int PS_RED  = 5;
  localparam int PS_MG   = 10;
  localparam int PS_IG   = 11;
  localparam logic [PSW-1:0] PS_SAVE_MASK = 12'hF3F;

  typedef enum logic [1:0] {GS_ALT, GS_MMU, GS_INT} gset_e;
endpackage

// File: rtl/trap_classify.sv
module trap_classify
  import trap_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CWPW = $clog2(NWIN)
) (
  input  logic [TTW-1:0]  tt,
  input  logic [CWPW-1:0] cwp,
  input  logic [CWPW-1:0] cansave,
  output gset_e           gset,
  output logic [CWPW-1:0] cwp_new
);
  logic mmu_range;

  always_comb begin
    mmu_range = (tt[TTW-1:2] == TT_INSN_MISS[TTW-1:2]) ||
                (tt[TTW-1:2] == TT_DATA_MISS[TTW-1:2]) ||
                (tt[TTW-1:2] == TT_DATA_PROT[TTW-1:2]);
    if (tt == TT_INT_VEC)
      gset = GS_INT;
    else if (tt == TT_INSN_FAULT || tt == TT_DATA_FAULT || mmu_range)
      gset = GS_MMU;
    else
      gset = GS_ALT;
  end

  always_comb begin
    if (tt == TT_CLEAN_WIN)
      cwp_new = cwp - CWPW'(1);
    else if (tt[8:6] == TT_GRP_SPILL)
      cwp_new = cwp - cansave - CWPW'(2);
    else if (tt[8:6] == TT_GRP_FILL)
      cwp_new = cwp + CWPW'(1);
    else
      cwp_new = cwp;
  end
endmodule

// File: rtl/trap_level.sv
module trap_level #(
  parameter int MAXTL = 5,
  localparam int TLW = $clog2(MAXTL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           take,
  output logic [TLW-1:0] tl,
  output logic           accept,
  output logic           reject,
  output logic           red_set
);
  localparam logic [TLW-1:0] TL_MAX  = TLW'(MAXTL);
  localparam logic [TLW-1:0] TL_EDGE = TLW'(MAXTL - 1);

  logic [TLW-1:0] tl_next;

  always_comb begin
    accept  = take && (tl < TL_MAX);
    reject  = take && (tl >= TL_MAX);
    red_set = 1'b0;
    tl_next = tl;
    if (accept) begin
      if (tl < TL_EDGE) begin
        tl_next = tl + TLW'(1);
      end else begin
        red_set = 1'b1;
        if (tl < TL_MAX) tl_next = tl + TLW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tl <= '0;
    else     tl <= tl_next;
  end

  a_r2_tl_step: assert property (@(posedge clk) disable iff (rst)
    (take && tl < TL_MAX) |=> (tl == $past(tl) + TLW'(1)));
  a_r1_tl_frozen: assert property (@(posedge clk) disable iff (rst)
    (take && tl >= TL_MAX) |=> $stable(tl));
  a_r2_tl_bound: assert property (@(posedge clk) disable iff (rst)
    tl <= TL_MAX);
endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
  parameter int DEPTH = 5,
  parameter int W     = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int NWIN  = 8,
  parameter int AW    = 64,
  localparam int CWPW = $clog2(NWIN),
  localparam int TLW  = $clog2(MAXTL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic [8:0]       tt_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    npc_i,
  input  logic [7:0]       ccr_i,
  input  logic [7:0]       asi_i,
  input  logic [11:0]      pstate_i,
  input  logic [CWPW-1:0]  cwp_i,
  input  logic [CWPW-1:0]  cansave_i,
  input  logic [AW-1:0]    tba_i,
  input  logic [TLW-1:0]   rd_lvl_i,
  output logic             done_o,
  output logic             err_o,
  output logic [TLW-1:0]   tl_o,
  output logic [11:0]      pstate_o,
  output logic [CWPW-1:0]  cwp_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o,
  output logic [39:0]      rd_tstate_o,
  output logic [AW-1:0]    rd_tpc_o,
  output logic [AW-1:0]    rd_tnpc_o,
  output logic [8:0]       rd_tt_o
);
  localparam int ENTW = SAVEW + 2 * AW + TTW;
  localparam int SAW  = (MAXTL > 1) ? $clog2(MAXTL) : 1;
  localparam logic [PSW-1:0] GMASK = PSW'((1 << PS_IG) | (1 << PS_MG) | (1 << PS_AG));

  logic             accept, reject, red_set;
  gset_e            gset;
  logic [CWPW-1:0]  cwp_new;
  logic [SAVEW-1:0] tstate;
  logic [PSW-1:0]   ps_new;
  logic [AW-1:0]    vec;
  logic [ENTW-1:0]  wentry, rentry;
  logic [TLW-1:0]   rd_idx;
  logic             unused_tba;

  assign unused_tba = ^tba_i[14:0];

  trap_level #(.MAXTL(MAXTL)) u_level (
    .clk(clk), .rst(rst), .take(take_i), .tl(tl_o),
    .accept(accept), .reject(reject), .red_set(red_set)
  );

  trap_classify #(.NWIN(NWIN)) u_class (
    .tt(tt_i), .cwp(cwp_i), .cansave(cansave_i),
    .gset(gset), .cwp_new(cwp_new)
  );

  always_comb begin
    tstate = '0;
    tstate[39:32] = ccr_i;
    tstate[31:24] = asi_i;
    tstate[19:8]  = pstate_i & PS_SAVE_MASK;
    tstate[CWPW-1:0] = cwp_i;
  end

  always_comb begin
    ps_new = pstate_i & ~GMASK;
    ps_new[PS_PEF]  = 1'b1;
    ps_new[PS_PRIV] = 1'b1;
    if (red_set) ps_new[PS_RED] = 1'b1;
    case (gset)
      GS_INT:  ps_new[PS_IG] = 1'b1;
      GS_MMU:  ps_new[PS_MG] = 1'b1;
      default: ps_new[PS_AG] = 1'b1;
    endcase
  end

  always_comb begin
    vec = tba_i;
    vec[14]   = (tl_o != '0);
    vec[13:5] = tt_i;
    vec[4:0]  = '0;
  end

  assign wentry = {tstate, pc_i, npc_i, tt_i};
  assign rd_idx = rd_lvl_i - TLW'(1);

  trap_stack #(.DEPTH(MAXTL), .W(ENTW)) u_stack (
    .clk(clk), .we(accept), .waddr(SAW'(tl_o)), .wdata(wentry),
    .raddr(SAW'(rd_idx)), .rdata(rentry)
  );

  assign {rd_tstate_o, rd_tpc_o, rd_tnpc_o, rd_tt_o} = rentry;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      pstate_o <= '0;
      cwp_o    <= '0;
      pc_o     <= '0;
      npc_o    <= '0;
    end else begin
      done_o <= accept;
      if (reject) err_o <= 1'b1;
      if (accept) begin
        pstate_o <= ps_new;
        cwp_o    <= cwp_new;
        pc_o     <= vec;
        npc_o    <= vec + AW'(4);
      end
    end
  end

  a_r1_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  a_r1_no_done_on_reject: assert property (@(posedge clk) disable iff (rst)
    (take_i && tl_o >= TLW'(MAXTL)) |=> (!done_o && err_o && $stable(pc_o)));
  a_r6_priv_bits: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pstate_o[PS_PEF] && pstate_o[PS_PRIV]));
  a_r6_one_gset: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones(pstate_o & GMASK) == 1));
  a_r8_vec_align: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (pc_o[4:0] == 5'd0 && pc_o[14] == (tl_o > TLW'(1))));
  a_r9_npc_step: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (npc_o == pc_o + AW'(4)));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(pc_o) && $stable(pstate_o) && !done_o));
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
  localparam int MAXTL = 5;
  localparam int NWIN  = 8;
  localparam int AW    = 64;
  localparam int CWPW  = 3;
  localparam int TLW   = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            take_i = 1'b0;
  logic [8:0]      tt_i = '0;
  logic [AW-1:0]   pc_i = '0, npc_i = '0, tba_i = '0;
  logic [7:0]      ccr_i = '0, asi_i = '0;
  logic [11:0]     pstate_i = '0;
  logic [CWPW-1:0] cwp_i = '0, cansave_i = '0;
  logic [TLW-1:0]  rd_lvl_i = 3'd1;
  logic            done_o, err_o;
  logic [TLW-1:0]  tl_o;
  logic [11:0]     pstate_o;
  logic [CWPW-1:0] cwp_o;
  logic [AW-1:0]   pc_o, npc_o, rd_tpc_o, rd_tnpc_o;
  logic [39:0]     rd_tstate_o;
  logic [8:0]      rd_tt_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  trap_entry_seq #(.MAXTL(MAXTL), .NWIN(NWIN), .AW(AW)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input logic [8:0] tt, input int seed);
    tt_i      = tt;
    pc_i      = {32'h1000_0000 ^ 32'(seed), 32'(seed * 8)};
    npc_i     = pc_i + 64'd4;
    ccr_i     = 8'(seed * 13 + 5);
    asi_i     = 8'(seed * 7 + 128);
    pstate_i  = 12'(seed * 37) ^ 12'hA5A;
    tba_i     = 64'hFFFF_0000_1234_5678 ^ {32'(seed), 32'h0};
    take_i    = 1'b1;
    @(negedge clk);
    take_i    = 1'b0;
  endtask

  function automatic logic [11:0] exp_ps(input logic [8:0] tt, input logic [11:0] pin, input bit red);
    logic [11:0] p;
    p = pin & ~12'hC01;
    p[4] = 1'b1;
    p[2] = 1'b1;
    if (red) p[5] = 1'b1;
    if (tt == 9'h060) p[11] = 1'b1;
    else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) p[10] = 1'b1;
    else p[0] = 1'b1;
    return p;
  endfunction

  function automatic logic [2:0] exp_cwp(input logic [8:0] tt, input int c, input int s);
    if (tt == 9'h024)           return 3'((c - 1) % NWIN + NWIN);
    else if (tt[8:6] == 3'b010) return 3'(c - s - 2 + 2 * NWIN);
    else if (tt[8:6] == 3'b011) return 3'(c + 1);
    return 3'(c);
  endfunction

  function automatic logic [63:0] exp_vec(input logic [63:0] tba, input logic [8:0] tt, input int newtl);
    return {tba[63:15], 1'(newtl > 1), tt, 5'd0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] vprev;
    do_reset();
    @(negedge clk);
    // R2 R10: reset state
    chk("R2 reset level", 64'(tl_o), 64'd0);
    chk("R10 reset done", 64'(done_o), 64'd0);
    chk("R1 reset err", 64'(err_o), 64'd0);

    // Sweep of every trap type from level 0
    for (int t = 0; t < 512; t++) begin
      do_reset();
      cwp_i = 3'(t);
      cansave_i = 3'(t >> 3);
      drive(9'(t), t);
      chk("R10 done pulse", 64'(done_o), 64'd1);
      chk("R2 level one", 64'(tl_o), 64'd1);
      chk("R6 R3 state word", 64'(pstate_o), 64'(exp_ps(9'(t), pstate_i, 1'b0)));
      chk("R7 window", 64'(cwp_o), 64'(exp_cwp(9'(t), int'(cwp_i), int'(cansave_i))));
      chk("R8 vector", pc_o, exp_vec(tba_i, 9'(t), 1));
      chk("R9 next pc", npc_o, exp_vec(tba_i, 9'(t), 1) + 64'd4);
      rd_lvl_i = 3'd1;
      @(negedge clk);
      chk("R10 done drops", 64'(done_o), 64'd0);
      chk("R4 saved word", 64'(rd_tstate_o),
          {24'd0, ccr_i, asi_i, 4'd0, pstate_i & 12'hF3F, 5'd0, cwp_i});
      chk("R5 saved pc", rd_tpc_o, pc_i);
      chk("R5 saved npc", rd_tnpc_o, npc_i);
      chk("R5 saved type", 64'(rd_tt_o), 64'(t));
    end

    // Window sweep for clean, spill and fill types
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < NWIN; c++) begin
        for (int s = 0; s < NWIN; s++) begin
          logic [8:0] tt;
          tt = (k == 0) ? 9'h024 : (k == 1) ? 9'h08C : 9'h0D4;
          do_reset();
          cwp_i = 3'(c);
          cansave_i = 3'(s);
          drive(tt, c * 8 + s);
          chk("R7 window sweep", 64'(cwp_o), 64'(exp_cwp(tt, c, s)));
        end
      end
    end

    // Saturation: climb to MAXTL, then one more trap
    do_reset();
    for (int l = 1; l <= MAXTL; l++) begin
      drive(9'h041 + 9'(l), 100 + l);
      chk("R2 climb level", 64'(tl_o), 64'(l));
      chk("R3 red at edge", 64'(pstate_o), 64'(exp_ps(tt_i, pstate_i, l == MAXTL)));
      chk("R8 level bit", pc_o, exp_vec(tba_i, tt_i, l));
    end
    vprev = pc_o;
    @(negedge clk);
    chk("R10 hold vector", pc_o, vprev);
    drive(9'h060, 999);
    chk("R1 error set", 64'(err_o), 64'd1);
    chk("R1 no done", 64'(done_o), 64'd0);
    chk("R1 level frozen", 64'(tl_o), 64'(MAXTL));
    chk("R1 vector kept", pc_o, vprev);
    rd_lvl_i = 3'(MAXTL);
    @(negedge clk);
    chk("R1 top entry kept", 64'(rd_tt_o), 64'(9'h041 + 9'(MAXTL)));
    chk("R1 error sticky", 64'(err_o), 64'd1);
    rd_lvl_i = 3'd2;
    @(negedge clk);
    chk("R5 level two entry", 64'(rd_tt_o), 64'h043);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule